// File: doc/BRIEF.md
# Single-Cycle Subset RISC Core

This block is a small processor core that completes one instruction every clock period. It supports seven operations on 32-bit words: unsigned add, unsigned subtract, OR with an immediate, word load, word store, branch when two registers are equal, and an absolute jump. Each cycle the program counter selects a word from the instruction array. The main decoder turns the opcode into datapath controls, and the ALU decoder refines R-type instructions by their funct field. The ALU result or the loaded word goes back to the register file at the next rising edge, and the program counter moves on to its next value at the same edge.

Instructions and data sit in two separate word arrays inside the top level. While the core is held in reset, a load port fills either array. A peek port reads any data word at any time. Each cycle the core shows its program counter, the register write it is about to commit and the store it is about to commit, so the surrounding logic can follow execution without seeing the internals.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, and during that cycle `wb_en` and `st_en` are 0. No register or data word changes while reset is high.
- R2: An instruction with opcode 0x00 and funct 0x21 writes rs+rt modulo 2^32 into register rd. With funct 0x23 it writes rs-rt modulo 2^32 into rd. The R-type fields are rs=[25:21], rt=[20:16] and rd=[15:11]. The program counter then advances by 4.
- R3: Opcode 0x0D writes rs OR {16'h0, imm[15:0]} into register rt. The immediate is zero-extended.
- R4: Opcode 0x23 writes into rt the data word at byte address rs + sign_ext(imm). The word index is address bits [AW+1:2].
- R5: Opcode 0x2B stores rt at byte address rs + sign_ext(imm) at the end of the cycle and writes no register. A load that follows the store sees the new word.
- R6: Opcode 0x04 with rs equal to rt sets the next program counter to PC+4+(sign_ext(imm)<<2), and a negative offset moves backwards. When rs and rt differ, the next program counter is PC+4. Neither case writes a register or memory.
- R7: Opcode 0x02 sets the next program counter to {PC+4[31:28], target[25:0], 2'b00} and writes nothing.
- R8: Register 0 always reads as 0, and writes to it are discarded.
- R9: An unknown opcode, or opcode 0x00 with a funct other than 0x21 or 0x23, writes no register and no memory. The program counter still advances by 4.
- R10: When an instruction both reads and writes the same register, it reads the value the register held before the edge. The following instruction reads the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 data array, 0 instruction array |
| ld_addr | input | AW | Preload word index |
| ld_data | input | 32 | Preload word |
| peek_addr | input | AW | Data array word index to observe |
| peek_data | output | 32 | Data word at peek_addr |
| pc_o | output | 32 | Current program counter |
| wb_en | output | 1 | A register write commits at the next edge |
| wb_reg | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value of that write |
| st_en | output | 1 | A data store commits at the next edge |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word being stored |

## Verification
Two things can happen to the same register in one cycle: it is read as an operand, and it is written as the destination. The program provokes this with a load whose base register is also its destination, followed directly by an add that reads that register. The load must use the old base to form its address, and the add must see the loaded word. A store followed at once by a load from the same word gives the same kind of collision on the memory side, and it is judged by the value the load writes back. A reset raised during a store cycle must cancel the store, and this is judged through the peek port.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    dst_rd;
        logic    b_imm;
        logic    wb_mem;
        logic    reg_we;
        logic    mem_we;
        logic    is_beq;
        logic    is_jmp;
        logic    ext_sign;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]      op;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [15:0]     imm;
    } ifmt_t;

    function automatic logic [XLEN-1:0] extend16(input logic [15:0] v, input logic sgn);
        return sgn ? {{(XLEN-16){v[15]}}, v} : {{(XLEN-16){1'b0}}, v};
    endfunction

    function automatic logic is_known_op(input logic [5:0] op);
        return (op == OP_RTYPE) || (op == OP_ORI) || (op == OP_LW) ||
               (op == OP_SW) || (op == OP_BEQ) || (op == OP_J);
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);
    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        unique case (op)
            OP_RTYPE: begin
                ctl.dst_rd = 1'b1;
                if (funct == FN_ADDU) begin
                    ctl.reg_we = 1'b1;
                    ctl.alu_op = ALU_ADD;
                end else if (funct == FN_SUBU) begin
                    ctl.reg_we = 1'b1;
                    ctl.alu_op = ALU_SUB;
                end
            end
            OP_ORI: begin
                ctl.b_imm  = 1'b1;
                ctl.reg_we = 1'b1;
                ctl.alu_op = ALU_OR;
            end
            OP_LW: begin
                ctl.b_imm    = 1'b1;
                ctl.ext_sign = 1'b1;
                ctl.wb_mem   = 1'b1;
                ctl.reg_we   = 1'b1;
            end
            OP_SW: begin
                ctl.b_imm    = 1'b1;
                ctl.ext_sign = 1'b1;
                ctl.mem_we   = 1'b1;
            end
            OP_BEQ: begin
                ctl.ext_sign = 1'b1;
                ctl.is_beq   = 1'b1;
                ctl.alu_op   = ALU_SUB;
            end
            OP_J: begin
                ctl.is_jmp = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  ra_a,
    input  logic [RAW-1:0]  ra_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b
);
    logic [XLEN-1:0] q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        if (g == 0) begin : g_zero
            assign q[g] = '0;
        end else begin : g_flop
            always_ff @(posedge clk) begin
                if (we && waddr == RAW'(g)) begin
                    q[g] <= wdata;
                end
            end
        end
    end

    assign rd_a = q[ra_a];
    assign rd_b = q[ra_b];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    localparam int AW = $clog2(MEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic            ld_dmem,
    input  logic [AW-1:0]   ld_addr,
    input  logic [31:0]     ld_data,
    input  logic [AW-1:0]   peek_addr,
    output logic [31:0]     peek_data,
    output logic [31:0]     pc_o,
    output logic            wb_en,
    output logic [4:0]      wb_reg,
    output logic [31:0]     wb_data,
    output logic            st_en,
    output logic [31:0]     st_addr,
    output logic [31:0]     st_data
);
    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_nx, pc_seq, br_tgt, j_tgt;
    logic [XLEN-1:0] instr, ext_imm, rs_val, rt_val, alu_b, alu_y, mem_rd, wb_val;
    logic            alu_zero, take_br;
    ifmt_t           f;
    ctrl_t           ctl;
    logic [RIDX-1:0] dst;
    logic            run_we_reg, run_we_mem;

    // fetch
    assign instr = imem[pc_q[AW+1:2]];
    assign f     = ifmt_t'(instr);

    sc_decode u_dec (
        .op    (f.op),
        .funct (f.imm[5:0]),
        .ctl   (ctl)
    );

    assign dst        = ctl.dst_rd ? f.imm[15:11] : f.rt;
    assign run_we_reg = ctl.reg_we & ~rst;
    assign run_we_mem = ctl.mem_we & ~rst;

    sc_regfile #(.NREG(1 << RIDX)) u_rf (
        .clk   (clk),
        .we    (run_we_reg),
        .waddr (dst),
        .wdata (wb_val),
        .ra_a  (f.rs),
        .ra_b  (f.rt),
        .rd_a  (rs_val),
        .rd_b  (rt_val)
    );

    assign ext_imm = extend16(f.imm, ctl.ext_sign);
    assign alu_b   = ctl.b_imm ? ext_imm : rt_val;

    sc_alu u_alu (
        .op   (ctl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: combinational read, write at the edge
    assign mem_rd = dmem[alu_y[AW+1:2]];
    assign wb_val = ctl.wb_mem ? mem_rd : alu_y;

    always_ff @(posedge clk) begin
        if (ld_en && !ld_dmem) begin
            imem[ld_addr] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_dmem) begin
            dmem[ld_addr] <= ld_data;
        end else if (run_we_mem) begin
            dmem[alu_y[AW+1:2]] <= rt_val;
        end
    end

    // next program counter: sequential adder plus a separate branch adder
    assign pc_seq  = pc_q + XLEN'(4);
    assign br_tgt  = pc_seq + {ext_imm[XLEN-3:0], 2'b00};
    assign j_tgt   = {pc_seq[XLEN-1:XLEN-4], instr[25:0], 2'b00};
    assign take_br = ctl.is_beq & alu_zero;

    always_comb begin
        if (ctl.is_jmp)    pc_nx = j_tgt;
        else if (take_br)  pc_nx = br_tgt;
        else               pc_nx = pc_seq;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nx;
    end

    assign pc_o      = pc_q;
    assign wb_en     = run_we_reg;
    assign wb_reg    = dst;
    assign wb_data   = wb_val;
    assign st_en     = run_we_mem;
    assign st_addr   = alu_y;
    assign st_data   = rt_val;
    assign peek_data = dmem[peek_addr];
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic        wb_en,
    input logic        st_en,
    input logic [31:0] instr
);
    logic [5:0]  op;
    logic [31:0] seq_pc, br_pc, jmp_pc;

    assign op     = instr[31:26];
    assign seq_pc = pc_o + 32'd4;
    assign br_pc  = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign jmp_pc = {seq_pc[31:28], instr[25:0], 2'b00};

    // R1
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc_o == 32'd0));

    // R5
    a_r5_store_no_wb: assert property (@(posedge clk) disable iff (rst)
        st_en |-> !wb_en);

    // R9
    a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
        !is_known_op(op) |-> (!wb_en && !st_en));

    // R2
    a_r2_seq_advance: assert property (@(posedge clk) disable iff (rst)
        (op != OP_BEQ && op != OP_J) |=> (pc_o == $past(seq_pc)));

    // R6
    a_r6_beq_next: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BEQ) |=> (pc_o == $past(seq_pc) || pc_o == $past(br_pc)));

    // R7
    a_r7_jump_next: assert property (@(posedge clk) disable iff (rst)
        (op == OP_J) |=> (pc_o == $past(jmp_pc)));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .pc_o  (pc_o),
    .wb_en (wb_en),
    .st_en (st_en),
    .instr (instr)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb_top;

    localparam int MW = 64;
    localparam int AW = $clog2(MW);
    localparam int WDOG_CYC = 20000;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input int tgt);
        return {6'h02, 26'(tgt)};
    endfunction

    localparam logic [31:0] PROG [25] = '{
        enc_i(6'h0D, 0, 1, 16'h8000),   // 0  ori r1
        enc_i(6'h0D, 0, 2, 16'h0004),   // 1  ori r2
        enc_i(6'h23, 2, 3, 16'hFFFC),   // 2  lw r3,-4(r2)
        enc_i(6'h23, 2, 4, 16'h0000),   // 3  lw r4,0(r2)
        enc_r(3, 4, 5, 6'h21),          // 4  addu r5
        enc_r(1, 2, 6, 6'h23),          // 5  subu r6
        enc_r(2, 1, 7, 6'h23),          // 6  subu r7 (wraps)
        enc_r(1, 1, 0, 6'h21),          // 7  addu r0 (discarded)
        enc_r(0, 1, 8, 6'h21),          // 8  addu r8 = r0+r1
        enc_i(6'h2B, 0, 5, 16'h0008),   // 9  sw r5,8(r0)
        enc_i(6'h23, 0, 9, 16'h0008),   // 10 lw r9,8(r0)
        enc_i(6'h04, 9, 5, 16'h0002),   // 11 beq taken
        enc_i(6'h0D, 0, 10, 16'h0BAD),  // 12 skipped
        enc_i(6'h0D, 0, 10, 16'h0BAD),  // 13 skipped
        enc_i(6'h04, 1, 2, 16'h0005),   // 14 beq not taken
        enc_i(6'h23, 2, 2, 16'h0000),   // 15 lw r2,0(r2)
        enc_r(2, 0, 11, 6'h21),         // 16 addu r11 = r2
        32'hFC00_0000,                  // 17 unknown opcode
        enc_r(1, 1, 12, 6'h25),         // 18 unknown funct
        enc_j(22),                      // 19 j 88
        enc_i(6'h0D, 0, 13, 16'h00FF),  // 20 ori r13
        enc_j(23),                      // 21 j 92
        enc_i(6'h04, 0, 0, 16'hFFFD),   // 22 beq back to 80
        enc_i(6'h2B, 0, 7, 16'h0010),   // 23 sw r7,16(r0)
        enc_j(24)                       // 24 j self
    };

    typedef struct packed {
        logic [31:0] pc;
        logic        wbe;
        logic [4:0]  wreg;
        logic [31:0] wdat;
        logic        ste;
        logic [31:0] sadr;
        logic [31:0] sdat;
    } step_t;

    localparam step_t TRACE [24] = '{
        '{32'h00, 1'b1, 5'd1,  32'h0000_8000, 1'b0, 32'h0,  32'h0},
        '{32'h04, 1'b1, 5'd2,  32'h0000_0004, 1'b0, 32'h0,  32'h0},
        '{32'h08, 1'b1, 5'd3,  32'h1234_5678, 1'b0, 32'h0,  32'h0},
        '{32'h0C, 1'b1, 5'd4,  32'hFFFF_0001, 1'b0, 32'h0,  32'h0},
        '{32'h10, 1'b1, 5'd5,  32'h1233_5679, 1'b0, 32'h0,  32'h0},
        '{32'h14, 1'b1, 5'd6,  32'h0000_7FFC, 1'b0, 32'h0,  32'h0},
        '{32'h18, 1'b1, 5'd7,  32'hFFFF_8004, 1'b0, 32'h0,  32'h0},
        '{32'h1C, 1'b1, 5'd0,  32'h0001_0000, 1'b0, 32'h0,  32'h0},
        '{32'h20, 1'b1, 5'd8,  32'h0000_8000, 1'b0, 32'h0,  32'h0},
        '{32'h24, 1'b0, 5'd0,  32'h0,         1'b1, 32'h8,  32'h1233_5679},
        '{32'h28, 1'b1, 5'd9,  32'h1233_5679, 1'b0, 32'h0,  32'h0},
        '{32'h2C, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0,  32'h0},
        '{32'h38, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0,  32'h0},
        '{32'h3C, 1'b1, 5'd2,  32'hFFFF_0001, 1'b0, 32'h0,  32'h0},
        '{32'h40, 1'b1, 5'd11, 32'hFFFF_0001, 1'b0, 32'h0,  32'h0},
        '{32'h44, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0,  32'h0},
        '{32'h48, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0,  32'h0},
        '{32'h4C, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0,  32'h0},
        '{32'h58, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0,  32'h0},
        '{32'h50, 1'b1, 5'd13, 32'h0000_00FF, 1'b0, 32'h0,  32'h0},
        '{32'h54, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0,  32'h0},
        '{32'h5C, 1'b0, 5'd0,  32'h0,         1'b1, 32'h10, 32'hFFFF_8004},
        '{32'h60, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0,  32'h0},
        '{32'h60, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0,  32'h0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic          ld_dmem = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [31:0]   peek_data, pc_o, wb_data, st_addr, st_data;
    logic          wb_en, st_en;
    logic [4:0]    wb_reg;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    sc_core #(.MEM_WORDS(MW)) dut_i (
        .clk (clk), .rst (rst),
        .ld_en (ld_en), .ld_dmem (ld_dmem), .ld_addr (ld_addr), .ld_data (ld_data),
        .peek_addr (peek_addr), .peek_data (peek_data),
        .pc_o (pc_o),
        .wb_en (wb_en), .wb_reg (wb_reg), .wb_data (wb_data),
        .st_en (st_en), .st_addr (st_addr), .st_data (st_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic d, input int a, input logic [31:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_dmem = d; ld_addr = AW'(a); ld_data = v;
    endtask

    task automatic peek(input string req, input int a, input logic [31:0] exp);
        peek_addr = AW'(a);
        #1;
        chk(req, $sformatf("dmem[%0d]", a), peek_data, exp);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R9 R10 are covered by the trace entries
    task automatic check_step(input int k);
        step_t s;
        s = TRACE[k];
        chk("R6/R7 pc", $sformatf("step %0d pc", k), pc_o, s.pc);
        chk("R9 wb_en", $sformatf("step %0d wb_en", k), 32'(wb_en), 32'(s.wbe));
        chk("R5 st_en", $sformatf("step %0d st_en", k), 32'(st_en), 32'(s.ste));
        if (s.wbe) begin
            chk("R2/R3/R4 wb_reg", $sformatf("step %0d", k), 32'(wb_reg), 32'(s.wreg));
            chk("R2/R3/R4/R8/R10 wb_data", $sformatf("step %0d", k), wb_data, s.wdat);
        end
        if (s.ste) begin
            chk("R5 st_addr", $sformatf("step %0d", k), st_addr, s.sadr);
            chk("R5 st_data", $sformatf("step %0d", k), st_data, s.sdat);
        end
    endtask

    initial begin
        for (int k = 0; k < 25; k++) load(1'b0, k, PROG[k]);
        for (int k = 0; k < 8; k++) begin
            load(1'b1, k, (k == 0) ? 32'h1234_5678 : (k == 1) ? 32'hFFFF_0001 : 32'h0);
        end
        @(negedge clk);
        ld_en = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "pc in reset", pc_o, 32'h0);
        chk("R1", "wb_en in reset", 32'(wb_en), 32'h0);
        chk("R1", "st_en in reset", 32'(st_en), 32'h0);

        @(negedge clk);
        rst = 1'b0;
        #1;
        check_step(0);
        for (int k = 1; k < 24; k++) begin
            @(negedge clk);
            #1;
            check_step(k);
        end

        // R5 stored words, untouched neighbours
        peek("R5", 2, 32'h1233_5679);
        peek("R5", 4, 32'hFFFF_8004);
        peek("R5", 0, 32'h1234_5678);
        peek("R5", 3, 32'h0);

        // R1: reset raised during a store cancels it
        @(negedge clk);
        rst = 1'b1;
        load(1'b1, 2, 32'hA5A5_A5A5);
        @(negedge clk);
        ld_en = 1'b0;
        rst = 1'b0;
        #1;
        check_step(0);
        for (int k = 1; k < 10; k++) begin
            @(negedge clk);
            #1;
            check_step(k);
        end
        rst = 1'b1;
        #1;
        chk("R1", "st_en under reset", 32'(st_en), 32'h0);
        chk("R1", "wb_en under reset", 32'(wb_en), 32'h0);
        @(negedge clk);
        #1;
        chk("R1", "pc after reset edge", pc_o, 32'h0);
        peek("R1", 2, 32'hA5A5_A5A5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(WDOG_CYC * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule